// File: doc/BRIEF.md
# Sixteen-bit ALU with status flags

This block is the arithmetic-logic unit of a small 16-bit microcontroller datapath. It is purely combinational: the execute stage presents a source operand, a destination operand, the current carry bit, a four-bit operation code and a byte/word select, and in the same cycle the unit returns the result, whether that result is to be written back, and the next values of the overflow (V), negative (N), zero (Z) and carry (C) status bits together with one update enable per bit.

The operation set covers binary addition and subtraction with and without carry, compare, bit test, AND, exclusive OR, bit set, bit clear, move, packed-BCD decimal addition, arithmetic right shift, rotate right through carry, byte swap and sign extension. Each operation has its own rule for which flags it changes and whether it writes a result. Instruction decode, the register file and memory access live outside this block.

Top module: `alu16_core`

## Requirements
- R1: The `op` encoding is ADD=0, ADDC=1, SUB=2, SUBC=3, CMP=4, DADD=5, BIT=6, BIC=7, BIS=8, XOR=9, AND=10, MOV=11, RRC=12, RRA=13, SWPB=14, SXT=15. ADD gives dst+src and ADDC gives dst+src+carry_in; C is the carry out of the sized sum.
- R2: SUB gives dst+NOT(src)+1, SUBC gives dst+NOT(src)+carry_in and CMP computes the SUB value; C is the carry out of that sum, and CMP does not request write-back.
- R3: For ADD, ADDC and DADD-free binary sums, V is set when both adder inputs (dst and src, or dst and NOT src for subtraction) share a sign bit and the result sign differs from it; for SUB, SUBC and CMP this equals "operand signs differ and the result sign differs from dst".
- R4: Whenever N or Z is updated, N equals the most significant bit of the sized result (bit 15 in word mode, bit 7 in byte mode) and Z is 1 exactly when the sized result is zero.
- R5: DADD adds src, dst and carry_in as packed BCD digits (four digits in word mode, two in byte mode); C is set when the decimal sum exceeds 9999 (word) or 99 (byte), V is cleared, and all four flags are updated. Results for non-BCD input digits are not defined.
- R6: AND and BIT compute src AND dst and XOR computes src XOR dst; for all three C = NOT Z. AND and BIT clear V; XOR sets V when both sized operands are negative. BIT does not request write-back.
- R7: BIC (NOT src AND dst), BIS (src OR dst) and MOV (src) write their result and update no flag; whenever a flag's update enable is 0 its value output is 0.
- R8: RRA shifts dst right keeping its sign bit, RRC shifts carry_in into the sign bit; both move the old bit 0 into C. RRA clears V; RRC sets V when dst was non-negative and carry_in is 1.
- R9: SWPB exchanges the two bytes of dst and updates no flag; SXT copies dst bit 7 into bits 8 to 15, clears V and sets C = NOT Z. Both always act on the full word, whatever `byte_mode` says.
- R10: With `byte_mode` = 1 every other operation works on bits 7..0, flags come from the 8-bit result, and result bits 15..8 are 0.
- R11: `wr_en` is 1 for every operation except CMP and BIT.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| src | input | 16 | Source operand |
| dst | input | 16 | Destination operand (the operand of single-operand operations) |
| carry_in | input | 1 | Current carry status bit |
| op | input | 4 | Operation code (encoding in R1) |
| byte_mode | input | 1 | 1 selects 8-bit operation |
| result | output | 16 | Computed result |
| wr_en | output | 1 | Result should be written back |
| flag_v | output | 1 | Next overflow bit |
| flag_n | output | 1 | Next negative bit |
| flag_z | output | 1 | Next zero bit |
| flag_c | output | 1 | Next carry bit |
| upd_v | output | 1 | Overflow bit is to be updated |
| upd_n | output | 1 | Negative bit is to be updated |
| upd_z | output | 1 | Zero bit is to be updated |
| upd_c | output | 1 | Carry bit is to be updated |

## Verification
The embedded assertions watch, for every input combination the unit sees, that N and Z agree with the sized result, that the logic operations report C as the inverse of Z, that a flag whose enable is low reads 0, that byte-mode results have a clear upper byte, and that each BCD digit out of the decimal adder stays within 0..9 for valid digit inputs. The arithmetic content itself (carry and overflow of binary sums, the decimal carry thresholds, the shift and swap bit movements, and the write-back choice per opcode) is shown only by the bench, which sweeps every opcode over a dense byte-mode grid and over word-mode corner and pseudo-random operands against its own arithmetic model.

// File: rtl/alu16_pkg.sv
// Shared definitions for the 16-bit ALU.
// Assumes a four-bit opcode; the numeric values are part of the block's interface.
package alu16_pkg;

    typedef enum logic [3:0] {
        OP_ADD  = 4'd0,
        OP_ADDC = 4'd1,
        OP_SUB  = 4'd2,
        OP_SUBC = 4'd3,
        OP_CMP  = 4'd4,
        OP_DADD = 4'd5,
        OP_BIT  = 4'd6,
        OP_BIC  = 4'd7,
        OP_BIS  = 4'd8,
        OP_XOR  = 4'd9,
        OP_AND  = 4'd10,
        OP_MOV  = 4'd11,
        OP_RRC  = 4'd12,
        OP_RRA  = 4'd13,
        OP_SWPB = 4'd14,
        OP_SXT  = 4'd15
    } alu_op_e;

endpackage

// File: rtl/alu16_binadd.sv
// Binary adder with carry in, carry out and signed-overflow output.
// Assumes: W >= 2. The caller inverts b for subtraction.
module alu16_binadd #(
    parameter int W = 16
) (
    input  logic [W-1:0] a,
    input  logic [W-1:0] b,
    input  logic         cin,
    output logic [W-1:0] sum,
    output logic         cout,
    output logic         ovf
);
    // Full-width sum including the carry out.
    always_comb begin
        {cout, sum} = {1'b0, a} + {1'b0, b} + {{W{1'b0}}, cin};
    end

    // Overflow: equal input signs, different result sign.
    always_comb begin
        ovf = (a[W-1] == b[W-1]) && (sum[W-1] != a[W-1]);
    end
endmodule

// File: rtl/alu16_bcdadd.sv
// Ripple packed-BCD adder of DIGITS four-bit decimal digits.
// Assumes every input digit is 0..9; other digits give an undefined sum.
// dcarry[i] is the decimal carry out of digit i.
module alu16_bcdadd #(
    parameter int DIGITS = 4,
    localparam int W = DIGITS * 4
) (
    input  logic [W-1:0]      a,
    input  logic [W-1:0]      b,
    input  logic              cin,
    output logic [W-1:0]      sum,
    output logic [DIGITS-1:0] dcarry
);
    logic [DIGITS:0] chain;
    assign chain[0] = cin;

    for (genvar g = 0; g < DIGITS; g++) begin : g_digit
        logic [4:0] raw;
        logic [4:0] fixed;
        // One decimal digit: binary add, then correct past nine.
        always_comb begin
            raw   = {1'b0, a[4*g +: 4]} + {1'b0, b[4*g +: 4]} + {4'b0, chain[g]};
            fixed = (raw > 5'd9) ? raw + 5'd6 : raw;
        end
        assign sum[4*g +: 4] = fixed[3:0];
        assign chain[g+1]    = (raw > 5'd9);
        assign dcarry[g]     = chain[g+1];

        // Digit range guard for valid BCD inputs (R5).
        always_comb begin
            if (a[4*g +: 4] <= 4'd9 && b[4*g +: 4] <= 4'd9)
                a_r5_digit_in_range: assert (sum[4*g +: 4] <= 4'd9)
                    else $error("BCD digit %0d out of range", g);
        end
    end
endmodule

// File: rtl/alu16_core.sv
// Combinational ALU for a 16-bit microcontroller datapath.
// Returns result, write-back request and V/N/Z/C next values with per-flag
// update enables. Byte mode works on the low half; SWPB and SXT are word-only.
// Assumes W is a multiple of 8 so both halves hold whole BCD digits.
module alu16_core
    import alu16_pkg::*;
#(
    parameter int W = 16
) (
    input  logic [W-1:0] src,
    input  logic [W-1:0] dst,
    input  logic         carry_in,
    input  logic [3:0]   op,
    input  logic         byte_mode,
    output logic [W-1:0] result,
    output logic         wr_en,
    output logic         flag_v,
    output logic         flag_n,
    output logic         flag_z,
    output logic         flag_c,
    output logic         upd_v,
    output logic         upd_n,
    output logic         upd_z,
    output logic         upd_c
);
    localparam int HALF  = W / 2;
    localparam int DIG   = W / 4;
    localparam int HDIG  = HALF / 4;

    alu_op_e    opc;
    logic       is_sub, word_only, sized_byte;
    logic [W-1:0] add_b;
    logic       add_cin;
    logic [W-1:0] sum_w;
    logic [HALF-1:0] sum_h;
    logic       co_w, co_h, ov_w, ov_h;
    logic [W-1:0] bcd_sum;
    logic [DIG-1:0] bcd_c;
    logic [W-1:0] raw;
    logic [W-1:0] sized;
    logic       msb_s, msb_d, lsb_d, zero;
    logic       v_raw, c_raw, c_is_notz, any_upd;

    assign opc = alu_op_e'(op);

    // Operand conditioning for the binary adders.
    always_comb begin
        is_sub  = (opc == OP_SUB) || (opc == OP_SUBC) || (opc == OP_CMP);
        add_b   = is_sub ? ~src : src;
        case (opc)
            OP_ADD:              add_cin = 1'b0;
            OP_SUB, OP_CMP:      add_cin = 1'b1;
            default:             add_cin = carry_in;
        endcase
        word_only  = (opc == OP_SWPB) || (opc == OP_SXT);
        sized_byte = byte_mode && !word_only;
    end

    alu16_binadd #(.W(W)) u_add_w (
        .a(dst), .b(add_b), .cin(add_cin),
        .sum(sum_w), .cout(co_w), .ovf(ov_w)
    );

    alu16_binadd #(.W(HALF)) u_add_h (
        .a(dst[HALF-1:0]), .b(add_b[HALF-1:0]), .cin(add_cin),
        .sum(sum_h), .cout(co_h), .ovf(ov_h)
    );

    alu16_bcdadd #(.DIGITS(DIG)) u_bcd (
        .a(dst), .b(src), .cin(carry_in),
        .sum(bcd_sum), .dcarry(bcd_c)
    );

    // Size-dependent operand bits used by shifts and flag rules.
    always_comb begin
        msb_s = sized_byte ? src[HALF-1] : src[W-1];
        msb_d = sized_byte ? dst[HALF-1] : dst[W-1];
        lsb_d = dst[0];
    end

    // Raw result, V and C per operation; C may be replaced by NOT Z later.
    always_comb begin
        raw       = '0;
        v_raw     = 1'b0;
        c_raw     = 1'b0;
        c_is_notz = 1'b0;
        any_upd   = 1'b1;
        wr_en     = 1'b1;
        case (opc)
            OP_ADD, OP_ADDC, OP_SUB, OP_SUBC, OP_CMP: begin
                raw   = sized_byte ? {{HALF{1'b0}}, sum_h} : sum_w;
                v_raw = sized_byte ? ov_h : ov_w;
                c_raw = sized_byte ? co_h : co_w;
                wr_en = (opc != OP_CMP);
            end
            OP_DADD: begin
                raw   = bcd_sum;
                c_raw = sized_byte ? bcd_c[HDIG-1] : bcd_c[DIG-1];
            end
            OP_BIT, OP_AND: begin
                raw       = src & dst;
                c_is_notz = 1'b1;
                wr_en     = (opc != OP_BIT);
            end
            OP_XOR: begin
                raw       = src ^ dst;
                v_raw     = msb_s & msb_d;
                c_is_notz = 1'b1;
            end
            OP_BIC: begin raw = ~src & dst; any_upd = 1'b0; end
            OP_BIS: begin raw = src | dst;  any_upd = 1'b0; end
            OP_MOV: begin raw = src;        any_upd = 1'b0; end
            OP_RRC: begin
                raw = {1'b0, dst[W-1:1]};
                if (sized_byte) raw[HALF-1] = carry_in;
                else            raw[W-1]    = carry_in;
                v_raw = carry_in & ~msb_d;
                c_raw = lsb_d;
            end
            OP_RRA: begin
                raw = {1'b0, dst[W-1:1]};
                if (sized_byte) raw[HALF-1] = msb_d;
                else            raw[W-1]    = msb_d;
                c_raw = lsb_d;
            end
            OP_SWPB: begin
                raw     = {dst[HALF-1:0], dst[W-1:HALF]};
                any_upd = 1'b0;
            end
            OP_SXT: begin
                raw       = {{HALF{dst[HALF-1]}}, dst[HALF-1:0]};
                c_is_notz = 1'b1;
            end
            default: ;
        endcase
    end

    // Apply operand size to the result.
    always_comb begin
        sized  = sized_byte ? {{HALF{1'b0}}, raw[HALF-1:0]} : raw;
        result = sized;
    end

    // Flag values and enables from the sized result.
    always_comb begin
        zero   = (sized == '0);
        upd_v  = any_upd;
        upd_n  = any_upd;
        upd_z  = any_upd;
        upd_c  = any_upd;
        flag_v = any_upd & v_raw;
        flag_n = any_upd & (sized_byte ? sized[HALF-1] : sized[W-1]);
        flag_z = any_upd & zero;
        flag_c = any_upd & (c_is_notz ? ~zero : c_raw);
    end

    // Guards on the combined outputs.
    always_comb begin
        if (upd_n)
            a_r4_n_is_msb: assert (flag_n == (sized_byte ? result[HALF-1] : result[W-1]))
                else $error("N does not follow result sign");
        if (upd_z)
            a_r4_z_is_zero: assert (flag_z == (sized_byte ? (result[HALF-1:0] == '0)
                                                          : (result == '0)))
                else $error("Z does not follow result");
        if (opc == OP_AND || opc == OP_BIT || opc == OP_XOR || opc == OP_SXT)
            a_r6_c_inverse_z: assert (flag_c == ~flag_z)
                else $error("C is not the inverse of Z");
        a_r7_quiet_flags_zero: assert ((upd_v || !flag_v) && (upd_n || !flag_n) &&
                                       (upd_z || !flag_z) && (upd_c || !flag_c))
            else $error("non-updated flag reads 1");
        if (byte_mode && !word_only)
            a_r10_byte_upper_clear: assert (result[W-1:HALF] == '0)
                else $error("byte result has upper bits set");
    end
endmodule

// File: tb/alu16_core_test.sv
// Self-checking bench: dense byte-mode grid over every opcode, decimal sweeps,
// and word-mode corner and pseudo-random operands, against an arithmetic model.
module alu16_core_test;
    localparam int CLK_PERIOD = 10;
    localparam int WATCHDOG_CYCLES = 150000;

    logic clk = 1'b0;
    always #(CLK_PERIOD/2) clk = ~clk;

    logic [15:0] src, dst;
    logic        carry_in, byte_mode;
    logic [3:0]  op;
    logic [15:0] result;
    logic        wr_en, flag_v, flag_n, flag_z, flag_c, upd_v, upd_n, upd_z, upd_c;

    int checks = 0;
    int errors = 0;
    bit finished = 1'b0;

    alu16_core uut (
        .src(src), .dst(dst), .carry_in(carry_in), .op(op), .byte_mode(byte_mode),
        .result(result), .wr_en(wr_en),
        .flag_v(flag_v), .flag_n(flag_n), .flag_z(flag_z), .flag_c(flag_c),
        .upd_v(upd_v), .upd_n(upd_n), .upd_z(upd_z), .upd_c(upd_c)
    );

    function automatic string req_of(input int o);
        case (o)
            0, 1:        return "R1";
            2, 3, 4:     return "R2";
            5:           return "R5";
            6, 9, 10:    return "R6";
            7, 8, 11:    return "R7";
            12, 13:      return "R8";
            default:     return "R9";
        endcase
    endfunction

    function automatic bit bcd_ok(input int v, input int nd);
        for (int i = 0; i < nd; i++) if (((v >> (4*i)) & 15) > 9) return 1'b0;
        return 1'b1;
    endfunction

    function automatic int from_bcd(input int v, input int nd);
        int r = 0, m = 1;
        for (int i = 0; i < nd; i++) begin r += ((v >> (4*i)) & 15) * m; m *= 10; end
        return r;
    endfunction

    function automatic int to_bcd(input int n, input int nd);
        int r = 0;
        for (int i = 0; i < nd; i++) begin r |= (n % 10) << (4*i); n /= 10; end
        return r;
    endfunction

    // Model from the requirements; exp = {result, wr, V,N,Z,C, uV,uN,uZ,uC}.
    task automatic model(input int o, input int s_in, input int d_in, input int c,
                         input int bm, output logic [24:0] exp, output bit valid);
        int wo, w, mask, s, d, r, v, cc, we, upd, sum, b, lim, nd, z, n;
        wo = (o == 14 || o == 15);
        w = (bm && !wo) ? 8 : 16;
        mask = (1 << w) - 1;
        s = s_in & mask; d = d_in & mask;
        v = 0; cc = 0; we = 1; upd = 1; valid = 1'b1; r = 0;
        case (o)
            0, 1, 2, 3, 4: begin
                b = (o >= 2) ? (~s & mask) : s;
                sum = d + b + ((o == 0) ? 0 : (o == 2 || o == 4) ? 1 : c);
                r = sum & mask; cc = (sum >> w) & 1;
                v = (((d ^ r) & (b ^ r)) >> (w - 1)) & 1;
                if (o == 4) we = 0;
            end
            5: begin
                nd = w / 4;
                lim = (w == 8) ? 99 : 9999;
                valid = bcd_ok(s, nd) && bcd_ok(d, nd);
                sum = from_bcd(s, nd) + from_bcd(d, nd) + c;
                cc = (sum > lim); r = to_bcd(sum % (lim + 1), nd);
            end
            6, 10: begin r = s & d; if (o == 6) we = 0; end
            9: begin r = s ^ d; v = ((s & d) >> (w - 1)) & 1; end
            7: begin r = ~s & d & mask; upd = 0; end
            8: begin r = s | d; upd = 0; end
            11: begin r = s; upd = 0; end
            12: begin
                r = (d >> 1) | (c << (w - 1)); cc = d & 1;
                v = c & ~(d >> (w - 1)) & 1;
            end
            13: begin r = (d >> 1) | (d & (1 << (w - 1))); cc = d & 1; end
            14: begin r = ((d & 255) << 8) | (d >> 8); upd = 0; end
            default: begin r = (d & 128) ? (d | 16'hff00) : (d & 255); end
        endcase
        z = (r == 0); n = (r >> (w - 1)) & 1;
        if (o == 6 || o == 9 || o == 10 || o == 15) cc = !z;
        if (!upd) begin v = 0; n = 0; z = 0; cc = 0; end
        exp = {r[15:0], we[0], v[0], n[0], z[0], cc[0], upd[0], upd[0], upd[0], upd[0]};
    endtask

    task automatic run(input int o, input int s, input int d, input int c, input int bm);
        logic [24:0] exp, got;
        bit valid;
        op = o[3:0]; src = s[15:0]; dst = d[15:0]; carry_in = c[0]; byte_mode = bm[0];
        #1;
        model(o, s, d, c, bm, exp, valid);
        if (!valid) return;
        got = {result, wr_en, flag_v, flag_n, flag_z, flag_c, upd_v, upd_n, upd_z, upd_c};
        checks++;
        if (got !== exp) begin
            errors++;
            $display("FAIL %s (R3 R4 R10 R11) op=%0d src=%h dst=%h c=%0d byte=%0d: got %h expected %h",
                     req_of(o), o, s, d, c, bm, got, exp);
        end
    endtask

    initial begin
        int corner [8] = '{0, 1, 16'h7fff, 16'h8000, 16'hffff, 16'h00ff, 16'h0080, 16'h5a3c};
        int lf = 16'hace1;
        src = '0; dst = '0; carry_in = 1'b0; op = '0; byte_mode = 1'b0;
        // Idle state: all-zero inputs give ADD of zeros (R1, R4).
        #(CLK_PERIOD/2);
        run(0, 0, 0, 0, 0);
        // Byte grid over every opcode (R10 for sizing, all ops).
        for (int o = 0; o < 16; o++)
            for (int s = 0; s < 256; s += 5)
                for (int d = 0; d < 256; d += 3)
                    for (int c = 0; c < 2; c++)
                        run(o, s | (((s * 7) & 255) << 8), d | (((d * 13) & 255) << 8), c, 1);
        // Word corners, every opcode (R3 overflow edges, R9 word-only).
        for (int o = 0; o < 16; o++)
            for (int i = 0; i < 8; i++)
                for (int j = 0; j < 8; j++)
                    for (int c = 0; c < 2; c++)
                        run(o, corner[i], corner[j], c, 0);
        // Word pseudo-random operands.
        for (int k = 0; k < 600; k++) begin
            int a, b;
            lf = (lf >> 1) ^ ((lf & 1) ? 16'hb400 : 0); a = lf;
            lf = (lf >> 1) ^ ((lf & 1) ? 16'hb400 : 0); b = lf;
            for (int o = 0; o < 16; o++) run(o, a, b, k & 1, 0);
        end
        // Decimal byte sweep, including the 99 carry boundary (R5).
        for (int a = 0; a < 100; a++)
            for (int b = 0; b < 100; b += 3)
                for (int c = 0; c < 2; c++)
                    run(5, to_bcd(b, 2), to_bcd(a, 2), c, 1);
        // Decimal word values around the 9999 boundary (R5).
        for (int k = 0; k < 2000; k++) begin
            int a = (k * 4973) % 10000, b = (k * 131 + 9000) % 10000;
            run(5, to_bcd(a, 4), to_bcd(b, 4), k & 1, 0);
        end
        run(5, to_bcd(9999, 4), to_bcd(0, 4), 1, 0);
        run(5, to_bcd(99, 2), to_bcd(0, 2), 1, 1);
        if (!finished) begin
            finished = 1'b1;
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        repeat (WATCHDOG_CYCLES) @(posedge clk);
        if (!finished) begin
            finished = 1'b1;
            errors++; checks++;
            $display("FAIL watchdog: run did not complete, got timeout expected completion");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end
endmodule